// File: doc/BRIEF.md
# Two-Accumulator Add/Subtract Unit with Carry and Overflow Flags

This block is the add/subtract datapath of a 24-bit two's-complement processor. It holds two accumulators, a primary one (A) and a secondary one (B), together with two status flags: a carry/borrow flag and an overflow flag. Each operation is presented as a 3-bit opcode, a 24-bit memory operand and a one-cycle valid strobe. The result is written on the next clock edge, and a done pulse marks the cycle in which the new accumulator and flag values appear.

The carry flag reflects a carry into the sign bit, or a borrow out of it, and not a carry out of the whole word. The overflow flag is sticky. Once it is set, it stays set until the program clears it. Two of the operations produce a value that goes back to memory: add-to-memory and increment-memory. These two leave both accumulators and both flags alone. Separate clear inputs reset each flag, and the flags drive output pins so that they can be tested.

Top module: `asu_unit`

## Requirements
- R1: After reset, both accumulators and the memory result are zero, both flags are clear, and done and mem_we are low.
- R2: Opcode 0 (add to A) writes A + operand into A.
- R3: Opcode 1 (subtract from A) writes A - operand into A.
- R4: For an add into A or B, the carry flag becomes 1 exactly when the sum of bits 22..0 of both addends (and any carry-in) carries into bit 23. Otherwise it becomes 0.
- R5: For a subtract from A or B, the carry flag becomes 1 exactly when bits 22..0 of the minuend are less than bits 22..0 of the subtrahend plus any borrow-in. Otherwise it becomes 0.
- R6: An add or subtract sets the overflow flag when the signed result does not fit in 24 bits. The flag is never cleared by an operation, only by the overflow clear input.
- R7: Opcode 2 (add with carry) writes A + operand + carry into A. Opcode 3 (subtract with borrow) writes A - operand - carry into A. Both use the carry flag value from before the operation and update the flags as in R4, R5 and R6.
- R8: Opcode 4 (add to B) writes B + operand into B, and opcode 5 (subtract from B) writes B - operand into B. Both update the flags and leave A unchanged.
- R9: Opcode 6 puts A + operand on mem_data. Opcode 7 puts operand + 1 on mem_data. For both, mem_we pulses, and A, B and both flags keep their values.
- R10: A high clr_carry or clr_ovf clears that flag on the next edge. When an opcode from 0 to 5 is valid in the same cycle, the operation's flag update takes precedence over the clear.
- R11: done is high for exactly the cycle after each valid strobe. A cycle with no strobe and no clear changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | Operation select (0..7, see requirements) |
| operand | input | 24 | Memory operand |
| clr_carry | input | 1 | Clear the carry flag |
| clr_ovf | input | 1 | Clear the overflow flag |
| acc_a | output | 24 | Primary accumulator |
| acc_b | output | 24 | Secondary accumulator |
| mem_data | output | 24 | Result of the last memory-bound operation |
| mem_we | output | 1 | Pulse: mem_data holds a new value for memory |
| done | output | 1 | Pulse: operation result and flags updated |
| carry_flag | output | 1 | Carry/borrow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The carry flag feeds the next add-with-carry or subtract-with-borrow. A wrong carry therefore shows up twice: on carry_flag in the done cycle, and again in the accumulator value one operation later. A lost sticky overflow shows on ovf_flag as soon as the next non-overflowing add completes. A memory-bound operation that leaks into the accumulators or flags is visible in the same done cycle. Because all of these show up within one or two operations, the bench compares every output after every operation against its own model.

// File: rtl/asu_pkg.sv
package asu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_A   = 3'd0,
        OP_SUB_A   = 3'd1,
        OP_ADC_A   = 3'd2,
        OP_SBB_A   = 3'd3,
        OP_ADD_B   = 3'd4,
        OP_SUB_B   = 3'd5,
        OP_ADD_MEM = 3'd6,
        OP_TALLY   = 3'd7
    } asu_op_e;

    // Operations that rewrite the carry flag and may raise overflow.
    function automatic logic op_sets_flags(asu_op_e op);
        return (op != OP_ADD_MEM) && (op != OP_TALLY);
    endfunction

    // Operations whose result goes back to memory.
    function automatic logic op_to_mem(asu_op_e op);
        return (op == OP_ADD_MEM) || (op == OP_TALLY);
    endfunction

endpackage

// File: rtl/asu_adder.sv
// Two's-complement add/subtract with the carry taken at the sign bit.
module asu_adder #(
    parameter int W = 24
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         cin,      // carry-in for add, borrow-in for subtract
    output logic [W-1:0] sum,
    output logic         sign_cy,  // carry into / borrow from the sign bit
    output logic         ovf
);
    localparam int SB = W - 1;

    logic [W-1:0] y_eff;
    logic         c_eff;
    logic [W-1:0] low;      // bit SB holds the carry into the sign position
    logic         c_sign;
    logic         msb;

    always_comb begin
        y_eff   = sub ? ~y : y;
        c_eff   = sub ? ~cin : cin;
        low     = {1'b0, x[SB-1:0]} + {1'b0, y_eff[SB-1:0]} + {{SB{1'b0}}, c_eff};
        c_sign  = low[SB];
        msb     = x[SB] ^ y_eff[SB] ^ c_sign;
        sum     = {msb, low[SB-1:0]};
        sign_cy = sub ? ~c_sign : c_sign;
        ovf     = (x[SB] == y_eff[SB]) && (msb != x[SB]);
    end
endmodule

// File: rtl/asu_flags.sv
// Next-state logic of the carry and sticky overflow flags.
module asu_flags (
    input  logic upd,
    input  logic cy_new,
    input  logic ov_new,
    input  logic clr_c,
    input  logic clr_o,
    input  logic cy_q,
    input  logic ov_q,
    output logic cy_d,
    output logic ov_d
);
    always_comb begin
        if (upd) begin
            cy_d = cy_new;
            ov_d = ov_q | ov_new;
        end else begin
            cy_d = clr_c ? 1'b0 : cy_q;
            ov_d = clr_o ? 1'b0 : ov_q;
        end
    end
endmodule

// File: rtl/asu_unit.sv
module asu_unit
    import asu_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] operand,
    input  logic         clr_carry,
    input  logic         clr_ovf,
    output logic [W-1:0] acc_a,
    output logic [W-1:0] acc_b,
    output logic [W-1:0] mem_data,
    output logic         mem_we,
    output logic         done,
    output logic         carry_flag,
    output logic         ovf_flag
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] mem;
        logic         mem_we;
        logic         done;
        logic         cy;
        logic         ov;
    } asu_state_t;

    asu_state_t st_d, st_q;
    asu_op_e    op;

    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_sub, add_cin, add_cy, add_ov;
    logic         flag_upd, cy_d, ov_d;

    assign op = asu_op_e'(op_code);

    // Operand routing for the single shared adder.
    always_comb begin
        add_x   = st_q.a;
        add_y   = operand;
        add_sub = 1'b0;
        add_cin = 1'b0;
        unique case (op)
            OP_ADD_A:   ;
            OP_SUB_A:   add_sub = 1'b1;
            OP_ADC_A:   add_cin = st_q.cy;
            OP_SBB_A: begin
                add_sub = 1'b1;
                add_cin = st_q.cy;
            end
            OP_ADD_B:   add_x = st_q.b;
            OP_SUB_B: begin
                add_x   = st_q.b;
                add_sub = 1'b1;
            end
            OP_ADD_MEM: ;
            OP_TALLY: begin
                add_x   = operand;
                add_y   = '0;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    asu_adder #(.W(W)) u_adder (
        .x       (add_x),
        .y       (add_y),
        .sub     (add_sub),
        .cin     (add_cin),
        .sum     (add_sum),
        .sign_cy (add_cy),
        .ovf     (add_ov)
    );

    assign flag_upd = op_valid && op_sets_flags(op);

    asu_flags u_flags (
        .upd    (flag_upd),
        .cy_new (add_cy),
        .ov_new (add_ov),
        .clr_c  (clr_carry),
        .clr_o  (clr_ovf),
        .cy_q   (st_q.cy),
        .ov_q   (st_q.ov),
        .cy_d   (cy_d),
        .ov_d   (ov_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = op_valid;
        st_d.mem_we = op_valid && op_to_mem(op);
        st_d.cy     = cy_d;
        st_d.ov     = ov_d;
        if (op_valid) begin
            unique case (op)
                OP_ADD_A, OP_SUB_A, OP_ADC_A, OP_SBB_A: st_d.a   = add_sum;
                OP_ADD_B, OP_SUB_B:                     st_d.b   = add_sum;
                OP_ADD_MEM, OP_TALLY:                   st_d.mem = add_sum;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_a      = st_q.a;
    assign acc_b      = st_q.b;
    assign mem_data   = st_q.mem;
    assign mem_we     = st_q.mem_we;
    assign done       = st_q.done;
    assign carry_flag = st_q.cy;
    assign ovf_flag   = st_q.ov;
endmodule

// File: rtl/asu_unit_chk.sv
module asu_unit_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_code,
    input logic         clr_carry,
    input logic         clr_ovf,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic         mem_we,
    input logic         done,
    input logic         carry_flag,
    input logic         ovf_flag
);
    logic is_mem_op, is_b_op, flag_op;
    assign is_mem_op = op_code[2] && op_code[1];
    assign is_b_op   = op_code[2] && !op_code[1];
    assign flag_op   = !is_mem_op;

    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    assert_no_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !clr_carry && !clr_ovf) |=>
        ($stable(acc_a) && $stable(acc_b) && $stable(carry_flag) && $stable(ovf_flag)));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    assert_mem_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_mem_op && !clr_carry && !clr_ovf) |=>
        ($stable(acc_a) && $stable(acc_b) && $stable(carry_flag) && $stable(ovf_flag) && mem_we));

    assert_mem_we_only_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_mem_op) |=> !mem_we);

    assert_b_keeps_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_b_op) |=> $stable(acc_a));

    assert_clear_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !(op_valid && flag_op)) |=> !ovf_flag);

    assert_clear_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_carry && !(op_valid && flag_op)) |=> !carry_flag);
endmodule

bind asu_unit asu_unit_chk #(.W(W)) i_asu_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .clr_carry  (clr_carry),
    .clr_ovf    (clr_ovf),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .mem_we     (mem_we),
    .done       (done),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/test_asu_unit.sv
`timescale 1ns/1ps
module test_asu_unit;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] operand = '0;
    logic         clr_carry = 1'b0;
    logic         clr_ovf = 1'b0;
    logic [W-1:0] acc_a, acc_b, mem_data;
    logic         mem_we, done, carry_flag, ovf_flag;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_a = '0, exp_b = '0, exp_mem = '0;
    logic         exp_c = 1'b0, exp_o = 1'b0;

    always #5 clk = ~clk;

    asu_unit #(.W(W)) i_asu_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .clr_carry(clr_carry), .clr_ovf(clr_ovf),
        .acc_a(acc_a), .acc_b(acc_b), .mem_data(mem_data), .mem_we(mem_we),
        .done(done), .carry_flag(carry_flag), .ovf_flag(ovf_flag)
    );

    // {ovf, carry, result}
    function automatic logic [W+1:0] model_add(logic [W-1:0] x, logic [W-1:0] y, logic ci);
        longint lo, s;
        logic   c, v;
        lo = longint'(x[W-2:0]) + longint'(y[W-2:0]) + longint'(ci);
        c  = lo >= (longint'(1) << (W-1));
        s  = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
        v  = (s > ((longint'(1) << (W-1)) - 1)) || (s < -(longint'(1) << (W-1)));
        return {v, c, W'(x + y + W'(ci))};
    endfunction

    function automatic logic [W+1:0] model_sub(logic [W-1:0] x, logic [W-1:0] y, logic bi);
        longint s;
        logic   c, v;
        c = longint'(x[W-2:0]) < (longint'(y[W-2:0]) + longint'(bi));
        s = longint'($signed(x)) - longint'($signed(y)) - longint'(bi);
        v = (s > ((longint'(1) << (W-1)) - 1)) || (s < -(longint'(1) << (W-1)));
        return {v, c, W'(x - y - W'(bi))};
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(logic [2:0] op, logic [W-1:0] m, logic cc, logic co);
        logic [W+1:0] r;
        logic flagop;
        flagop = 1'b1;
        case (op)
            3'd0: r = model_add(exp_a, m, 1'b0);
            3'd1: r = model_sub(exp_a, m, 1'b0);
            3'd2: r = model_add(exp_a, m, exp_c);
            3'd3: r = model_sub(exp_a, m, exp_c);
            3'd4: r = model_add(exp_b, m, 1'b0);
            3'd5: r = model_sub(exp_b, m, 1'b0);
            3'd6: begin r = model_add(exp_a, m, 1'b0); flagop = 1'b0; end
            default: begin r = model_add(m, '0, 1'b1); flagop = 1'b0; end
        endcase
        if (op <= 3'd3)      exp_a = r[W-1:0];
        else if (op <= 3'd5) exp_b = r[W-1:0];
        else                 exp_mem = r[W-1:0];
        if (flagop) begin
            exp_c = r[W];
            exp_o = exp_o | r[W+1];
        end else begin
            if (cc) exp_c = 1'b0;
            if (co) exp_o = 1'b0;
        end
    endtask

    task automatic check_all(logic [2:0] op, logic was_op);
        string vt, ct;
        case (op)
            3'd0: vt = "R2";
            3'd1: vt = "R3";
            3'd2, 3'd3: vt = "R7";
            3'd4, 3'd5: vt = "R8";
            default: vt = "R9";
        endcase
        ct = (op == 3'd1 || op == 3'd3 || op == 3'd5) ? "R5" : "R4";
        if (op >= 3'd6) ct = "R9";
        chk(vt, "acc_a", acc_a, exp_a);
        chk(vt, "acc_b", acc_b, exp_b);
        chk(ct, "carry_flag", W'(carry_flag), W'(exp_c));
        chk("R6", "ovf_flag", W'(ovf_flag), W'(exp_o));
        chk("R11", "done", W'(done), W'(was_op));
        chk("R9", "mem_we", W'(mem_we), W'(was_op && op >= 3'd6));
        if (was_op && op >= 3'd6) chk("R9", "mem_data", mem_data, exp_mem);
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic do_op(logic [2:0] op, logic [W-1:0] m, logic cc, logic co);
        op_valid = 1'b1; op_code = op; operand = m; clr_carry = cc; clr_ovf = co;
        @(negedge clk);
        model_step(op, m, cc, co);
        check_all(op, 1'b1);
        op_valid = 1'b0; clr_carry = 1'b0; clr_ovf = 1'b0;
    endtask

    task automatic do_clear(logic cc, logic co);
        clr_carry = cc; clr_ovf = co;
        @(negedge clk);
        if (cc) exp_c = 1'b0;
        if (co) exp_o = 1'b0;
        chk("R10", "carry after clear", W'(carry_flag), W'(exp_c));
        chk("R10", "ovf after clear", W'(ovf_flag), W'(exp_o));
        chk("R11", "done on clear-only cycle", W'(done), '0);
        clr_carry = 1'b0; clr_ovf = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "acc_a reset", acc_a, '0);
        chk("R1", "acc_b reset", acc_b, '0);
        chk("R1", "mem_data reset", mem_data, '0);
        chk("R1", "flags reset", W'({carry_flag, ovf_flag, done, mem_we}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R6: test sequence of repeated quarter-range additions
        do_op(3'd0, 24'o20000000, 1'b0, 1'b0);
        do_op(3'd0, 24'o20000000, 1'b0, 1'b0);
        chk("R4", "vector step1 A", acc_a, 24'o40000000);
        chk("R4", "vector step1 carry", W'(carry_flag), W'(1));
        do_op(3'd0, 24'o20000000, 1'b0, 1'b0);
        chk("R4", "vector step2 carry", W'(carry_flag), W'(0));
        chk("R6", "vector step2 ovf sticky", W'(ovf_flag), W'(1));
        do_op(3'd0, 24'o20000000, 1'b0, 1'b0);
        chk("R4", "vector step3 A", acc_a, '0);
        chk("R6", "vector step3 ovf", W'(ovf_flag), W'(1));

        // R11 idle cycle changes nothing
        @(negedge clk);
        check_all(3'd0, 1'b0);

        // R10 clears alone
        do_clear(1'b1, 1'b1);

        // R5 borrow boundary: equal low parts, then low part one short
        do_op(3'd1, 24'h000010, 1'b0, 1'b0);      // 0 - 0x10: borrow
        do_op(3'd1, 24'h7FFFF0, 1'b0, 1'b0);
        do_op(3'd3, 24'h000001, 1'b0, 1'b0);      // R7 SBB with current carry
        do_op(3'd2, 24'h7FFFFF, 1'b0, 1'b0);      // R7 ADC

        // R8 B ops including signed overflow on subtract
        do_op(3'd4, 24'h7FFFFF, 1'b0, 1'b0);
        do_op(3'd5, 24'h800000, 1'b0, 1'b0);

        // R10 clear concurrent with a flag-updating operation: operation wins
        do_op(3'd0, 24'h400000, 1'b1, 1'b1);
        chk("R10", "ovf kept over clear", W'(ovf_flag), W'(exp_o));

        // R9 memory ops: tally wrap and add-to-memory, clears still apply
        do_op(3'd7, 24'hFFFFFF, 1'b0, 1'b0);
        chk("R9", "tally wrap", mem_data, '0);
        do_op(3'd6, 24'h123456, 1'b0, 1'b0);
        do_op(3'd7, 24'h00ABCD, 1'b1, 1'b1);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0]   rop;
            logic [W-1:0] rm;
            logic         rcc, rco;
            rop = 3'($urandom());
            case ($urandom() % 4)
                0: rm = 24'h800000;
                1: rm = 24'h7FFFFF;
                default: rm = W'($urandom());
            endcase
            rcc = ($urandom() % 8) == 0;
            rco = ($urandom() % 8) == 0;
            do_op(rop, rm, rcc, rco);
            if (($urandom() % 6) == 0) begin
                @(negedge clk);
                check_all(rop, 1'b0);
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule